// File: doc/BRIEF.md
# UART Channel Interrupt Status Concentrator

This block collects the interrupt identification value and two line-status bits from each of four UART channels and packs them into one 32-bit read-only summary word. Alongside the identification fields, it computes a per-channel "good data" flag. When a channel's flag is set, software can drain that channel's receive FIFO by its level count alone, without first reading the channel's line status register. A global flag is set only when every channel is clean.

The summary word is registered on every clock. It sits in a small decode window next to three other words that are passed through from outside the block: the receive level word, the transmit level word and the global interrupt status word. Because the four words occupy consecutive offsets, software can fetch all of them in one burst. The level words come first, so the good-data flags read afterwards cover the byte counts just read. Nothing in the window can be written.

Top module: `irqsum_top`

## Requirements
- R1: In the summary word, channel 0's 6-bit identification sits in bits 5:0, channel 1's in 11:6, channel 2's in 17:12 and channel 3's in 23:18.
- R2: Summary bits 26:24 always read 0.
- R3: A channel's good-data flag is 1 only when its identification is 01h (nothing pending), 04h (receive data), 0Ch (receive timeout) or 02h (transmit empty). Any other value, such as 06h or 00h, gives 0. The flags for channels 0..3 appear in summary bits 27..30 and on `good_o[0..3]`.
- R4: A set error-in-FIFO line-status bit (`lsr_err_i`, line status bit 7) forces that channel's good-data flag to 0.
- R5: A set overrun line-status bit (`lsr_ovr_i`, line status bit 1) forces that channel's good-data flag to 0.
- R6: Summary bit 31 and `all_good_o` equal the AND of the four good-data flags.
- R7: While reset is asserted, the summary word is F804_1041h: every identification field is 01h, the reserved bits are 0 and all five flag bits are 1.
- R8: The summary word reflects the channel inputs sampled at the previous rising clock edge. It does not follow the inputs between edges.
- R9: A read (`rd_en_i` high, `wr_en_i` low) returns data on `rdata_o` with `rvalid_o` high one cycle later. Offset 10h returns `rx_lvl_i`, 14h returns `tx_lvl_i`, 18h returns the summary word and 1Ch returns `gis_i`.
- R10: A read of any other byte offset returns 0 with `rvalid_o` high.
- R11: A cycle with `wr_en_i` high returns no data (`rvalid_o` stays low) and changes no readable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iid_i | input | 24 | Identification values; channel c in bits 6c+5:6c |
| lsr_err_i | input | 4 | Per-channel error-in-FIFO line-status bit |
| lsr_ovr_i | input | 4 | Per-channel overrun line-status bit |
| rx_lvl_i | input | 32 | Receive level word, returned at 10h |
| tx_lvl_i | input | 32 | Transmit level word, returned at 14h |
| gis_i | input | 32 | Global interrupt status word, returned at 1Ch |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (ignored apart from suppressing a read) |
| addr_i | input | 8 | Byte offset |
| summary_o | output | 32 | Registered summary word |
| good_o | output | 4 | Per-channel good-data flags |
| all_good_o | output | 1 | AND of all good-data flags |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit offset and the offsets 10h, 14h, 18h and 1Ch. With four channels, every identification field and every flag position of the 32-bit word is in use. The reserved gap and the global AND can therefore be exercised with each channel failing on its own, by an unclean code, an error bit or an overrun bit. The 8-bit offset lets the bench probe unmapped offsets just below, between and beyond the window, including a misaligned one.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
  localparam int IID_W  = 6;
  localparam int RSVD_W = 3;

  typedef logic [IID_W-1:0] iid_t;

  localparam iid_t IID_NONE   = 6'h01;
  localparam iid_t IID_RXDATA = 6'h04;
  localparam iid_t IID_RXTMO  = 6'h0C;
  localparam iid_t IID_THRE   = 6'h02;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXLVL,
    SEL_TXLVL,
    SEL_SUM,
    SEL_GIS
  } reg_sel_e;

  // Codes that leave no error or modem event for software to handle
  function automatic logic iid_is_clean(iid_t v);
    case (v)
      IID_NONE, IID_RXDATA, IID_RXTMO, IID_THRE: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irqsum_chan_qual.sv
module irqsum_chan_qual
  import irqsum_pkg::*;
(
  input  iid_t iid_i,
  input  logic lsr_err_i,
  input  logic lsr_ovr_i,
  output logic good_o
);
  logic code_ok;

  always_comb begin
    code_ok = iid_is_clean(iid_i);
    good_o  = code_ok & ~lsr_err_i & ~lsr_ovr_i;
  end
endmodule

// File: rtl/irqsum_pack.sv
module irqsum_pack
  import irqsum_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*IID_W-1:0] iid_i,
  input  logic [NUM_CH-1:0]       good_i,
  output logic [DATA_W-1:0]       word_o
);
  localparam int IID_FLD_W  = NUM_CH * IID_W;
  localparam int GOOD_LSB   = IID_FLD_W + RSVD_W;
  localparam int GLOBAL_BIT = GOOD_LSB + NUM_CH;

  function automatic logic [DATA_W-1:0] rst_word();
    logic [DATA_W-1:0] w;
    w = '0;
    for (int c = 0; c < NUM_CH; c++) w[c*IID_W +: IID_W] = IID_NONE;
    w[GOOD_LSB +: NUM_CH] = '1;
    w[GLOBAL_BIT]         = 1'b1;
    return w;
  endfunction

  localparam logic [DATA_W-1:0] RST_WORD = rst_word();

  logic [DATA_W-1:0] word_d, word_q;

  always_comb begin
    word_d = '0;
    word_d[IID_FLD_W-1:0]       = iid_i;
    word_d[GOOD_LSB +: NUM_CH]  = good_i;
    word_d[GLOBAL_BIT]          = &good_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= RST_WORD;
    else         word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/irqsum_rd_mux.sv
module irqsum_rd_mux
  import irqsum_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] OFS_RXLVL = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_TXLVL = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_SUM   = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_GIS   = 8'h1C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rx_lvl_i,
  input  logic [DATA_W-1:0] tx_lvl_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [DATA_W-1:0] gis_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  reg_sel_e          sel;
  logic              rd_fire;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              rvalid_q;

  // A write strobe turns the cycle into a write, which is dropped
  assign rd_fire = rd_en_i & ~wr_en_i;

  always_comb begin
    if      (addr_i == OFS_RXLVL) sel = SEL_RXLVL;
    else if (addr_i == OFS_TXLVL) sel = SEL_TXLVL;
    else if (addr_i == OFS_SUM)   sel = SEL_SUM;
    else if (addr_i == OFS_GIS)   sel = SEL_GIS;
    else                          sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_RXLVL: rdata_d = rx_lvl_i;
      SEL_TXLVL: rdata_d = tx_lvl_i;
      SEL_SUM:   rdata_d = sum_i;
      SEL_GIS:   rdata_d = gis_i;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rdata_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/irqsum_top.sv
module irqsum_top
  import irqsum_pkg::*;
#(
  parameter int                NUM_CH    = 4,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] OFS_RXLVL = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_TXLVL = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_SUM   = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_GIS   = 8'h1C
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*IID_W-1:0] iid_i,
  input  logic [NUM_CH-1:0]       lsr_err_i,
  input  logic [NUM_CH-1:0]       lsr_ovr_i,
  input  logic [DATA_W-1:0]       rx_lvl_i,
  input  logic [DATA_W-1:0]       tx_lvl_i,
  input  logic [DATA_W-1:0]       gis_i,
  input  logic                    rd_en_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [DATA_W-1:0]       summary_o,
  output logic [NUM_CH-1:0]       good_o,
  output logic                    all_good_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rvalid_o
);
  localparam int GOOD_LSB   = NUM_CH * IID_W + RSVD_W;
  localparam int GLOBAL_BIT = GOOD_LSB + NUM_CH;

  logic [NUM_CH-1:0] good_comb;
  logic [DATA_W-1:0] sum_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irqsum_chan_qual u_qual (
      .iid_i     (iid_i[c*IID_W +: IID_W]),
      .lsr_err_i (lsr_err_i[c]),
      .lsr_ovr_i (lsr_ovr_i[c]),
      .good_o    (good_comb[c])
    );
  end

  irqsum_pack #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .iid_i  (iid_i),
    .good_i (good_comb),
    .word_o (sum_q)
  );

  irqsum_rd_mux #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .OFS_RXLVL (OFS_RXLVL),
    .OFS_TXLVL (OFS_TXLVL),
    .OFS_SUM   (OFS_SUM),
    .OFS_GIS   (OFS_GIS)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .rx_lvl_i (rx_lvl_i),
    .tx_lvl_i (tx_lvl_i),
    .sum_i    (sum_q),
    .gis_i    (gis_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign summary_o  = sum_q;
  assign good_o     = sum_q[GOOD_LSB +: NUM_CH];
  assign all_good_o = sum_q[GLOBAL_BIT];
endmodule

// File: rtl/irqsum_chk.sv
module irqsum_chk
  import irqsum_pkg::*;
#(
  parameter int                NUM_CH    = 4,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] OFS_RXLVL = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_TXLVL = 8'h14,
  parameter logic [ADDR_W-1:0] OFS_SUM   = 8'h18,
  parameter logic [ADDR_W-1:0] OFS_GIS   = 8'h1C
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH*IID_W-1:0] iid_i,
  input logic [NUM_CH-1:0]       lsr_err_i,
  input logic [NUM_CH-1:0]       lsr_ovr_i,
  input logic [DATA_W-1:0]       rx_lvl_i,
  input logic [DATA_W-1:0]       tx_lvl_i,
  input logic [DATA_W-1:0]       gis_i,
  input logic                    rd_en_i,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       summary_o,
  input logic [NUM_CH-1:0]       good_o,
  input logic                    all_good_o,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    rvalid_o
);
  localparam int IID_FLD_W = NUM_CH * IID_W;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic unmapped;
  assign unmapped = (addr_i != OFS_RXLVL) && (addr_i != OFS_TXLVL) &&
                    (addr_i != OFS_SUM) && (addr_i != OFS_GIS);

  AST_IID_PACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> summary_o[IID_FLD_W-1:0] == $past(iid_i)); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    summary_o[IID_FLD_W +: RSVD_W] == '0); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !iid_is_clean($past(iid_i[c*IID_W +: IID_W])) |-> !good_o[c]); // R3
    AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(lsr_err_i[c]) |-> !good_o[c]); // R4
    AST_OVR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(lsr_ovr_i[c]) |-> !good_o[c]); // R5
  end

  AST_GLOBAL_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_good_o == &good_o); // R6

  AST_RESET_VAL: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> summary_o == 32'hF804_1041); // R7

  AST_RVALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> rvalid_o == $past(rd_en_i && !wr_en_i)); // R9

  AST_RD_RXLVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(rd_en_i && !wr_en_i && addr_i == OFS_RXLVL) |-> rdata_o == $past(rx_lvl_i)); // R9

  AST_RD_TXLVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(rd_en_i && !wr_en_i && addr_i == OFS_TXLVL) |-> rdata_o == $past(tx_lvl_i)); // R9

  AST_RD_GIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(rd_en_i && !wr_en_i && addr_i == OFS_GIS) |-> rdata_o == $past(gis_i)); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(rd_en_i && !wr_en_i && unmapped) |-> rdata_o == '0); // R10

  AST_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(wr_en_i) |-> !rvalid_o); // R11
endmodule

bind irqsum_top irqsum_chk #(
  .NUM_CH    (NUM_CH),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .OFS_RXLVL (OFS_RXLVL),
  .OFS_TXLVL (OFS_TXLVL),
  .OFS_SUM   (OFS_SUM),
  .OFS_GIS   (OFS_GIS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .iid_i      (iid_i),
  .lsr_err_i  (lsr_err_i),
  .lsr_ovr_i  (lsr_ovr_i),
  .rx_lvl_i   (rx_lvl_i),
  .tx_lvl_i   (tx_lvl_i),
  .gis_i      (gis_i),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .summary_o  (summary_o),
  .good_o     (good_o),
  .all_good_o (all_good_o),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/irqsum_top_tb_top.sv
module irqsum_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [23:0] iid_i;
  logic [3:0]  lsr_err_i, lsr_ovr_i;
  logic [31:0] rx_lvl_i, tx_lvl_i, gis_i;
  logic        rd_en_i, wr_en_i;
  logic [7:0]  addr_i;
  logic [31:0] summary_o, rdata_o;
  logic [3:0]  good_o;
  logic        all_good_o, rvalid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0] iid_m [4];
  logic [3:0] err_m, ovr_m;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  irqsum_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .iid_i      (iid_i),
    .lsr_err_i  (lsr_err_i),
    .lsr_ovr_i  (lsr_ovr_i),
    .rx_lvl_i   (rx_lvl_i),
    .tx_lvl_i   (tx_lvl_i),
    .gis_i      (gis_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .summary_o  (summary_o),
    .good_o     (good_o),
    .all_good_o (all_good_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic chan_good(int c);
    logic code_ok;
    code_ok = (iid_m[c] == 6'h01) || (iid_m[c] == 6'h04) ||
              (iid_m[c] == 6'h0C) || (iid_m[c] == 6'h02);
    return code_ok && !err_m[c] && !ovr_m[c];
  endfunction

  // Model of the summary word from R1..R6
  function automatic logic [31:0] model();
    logic [31:0] w;
    w = '0;
    for (int c = 0; c < 4; c++) begin
      w[c*6 +: 6] = iid_m[c];
      w[27 + c]   = chan_good(c);
    end
    w[31] = &w[30:27];
    return w;
  endfunction

  task automatic drive();
    for (int c = 0; c < 4; c++) iid_i[c*6 +: 6] = iid_m[c];
    lsr_err_i = err_m;
    lsr_ovr_i = ovr_m;
  endtask

  task automatic set_ch(int c, logic [5:0] iid, logic err, logic ovr);
    iid_m[c] = iid;
    err_m[c] = err;
    ovr_m[c] = ovr;
  endtask

  // Called at a negedge: drive, let one edge pass, check outputs, read 18h
  task automatic apply(string tag);
    logic [31:0] m;
    drive();
    @(negedge clk);
    m = model();
    chk({tag, " summary"}, summary_o, m);
    chk({tag, " good_o"}, {28'd0, good_o}, {28'd0, m[30:27]});
    chk({tag, " all_good_o"}, {31'd0, all_good_o}, {31'd0, m[31]});
    rd(8'h18, m, {tag, " read 18h"});
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    rd_en_i = 1'b1;
    addr_i  = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  // Monitor: pops one expectation per valid read beat
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  initial begin
    rd_en_i = 0; wr_en_i = 0; addr_i = '0;
    rx_lvl_i = 32'h1122_3344; tx_lvl_i = 32'h5566_7788; gis_i = 32'h99AA_BBCC;
    for (int c = 0; c < 4; c++) set_ch(c, 6'h01, 1'b0, 1'b0);
    drive();
    #5 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset summary", summary_o, 32'hF804_1041);
    chk("R7 reset good_o", {28'd0, good_o}, 32'h0000_000F);
    chk("R7 reset all_good_o", {31'd0, all_good_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk);

    set_ch(0, 6'h01, 0, 0); set_ch(1, 6'h04, 0, 0);
    set_ch(2, 6'h0C, 0, 0); set_ch(3, 6'h02, 0, 0);
    apply("R3 all clean codes");

    set_ch(1, 6'h06, 0, 0);
    apply("R3 R6 ch1 line status code");

    set_ch(1, 6'h04, 0, 0); set_ch(2, 6'h00, 0, 0);
    apply("R3 R6 ch2 modem code");

    set_ch(2, 6'h0C, 0, 0); set_ch(3, 6'h02, 1, 0);
    apply("R4 ch3 error bit");

    set_ch(3, 6'h02, 0, 0); set_ch(0, 6'h01, 0, 1);
    apply("R5 ch0 overrun bit");

    set_ch(0, 6'h3F, 0, 0); set_ch(1, 6'h2A, 0, 0);
    set_ch(2, 6'h15, 0, 0); set_ch(3, 6'h33, 0, 0);
    apply("R1 field packing");
    chk("R2 reserved bits", {29'd0, summary_o[26:24]}, 32'd0);

    // R8: output holds until the next rising edge
    begin
      logic [31:0] prev;
      prev = summary_o;
      set_ch(0, 6'h04, 0, 0); set_ch(1, 6'h04, 0, 0);
      set_ch(2, 6'h04, 0, 0); set_ch(3, 6'h04, 0, 0);
      drive();
      #2;
      chk("R8 holds before edge", summary_o, prev);
      @(negedge clk);
      chk("R8 updates after edge", summary_o, model());
    end

    rd(8'h10, rx_lvl_i, "R9 read 10h");
    rd(8'h14, tx_lvl_i, "R9 read 14h");
    rd(8'h1C, gis_i,    "R9 read 1Ch");
    rd(8'h18, model(),  "R9 read 18h");

    rd(8'h00, 32'd0, "R10 read 00h");
    rd(8'h0C, 32'd0, "R10 read 0Ch");
    rd(8'h20, 32'd0, "R10 read 20h");
    rd(8'h19, 32'd0, "R10 read 19h");
    rd(8'hFC, 32'd0, "R10 read FCh");

    // R11: write cycles return nothing and change nothing
    wr_en_i = 1'b1; rd_en_i = 1'b1; addr_i = 8'h18;
    @(negedge clk);
    chk("R11 no rvalid on write", {31'd0, rvalid_o}, 32'd0);
    addr_i = 8'h10;
    @(negedge clk);
    chk("R11 no rvalid on write 10h", {31'd0, rvalid_o}, 32'd0);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    rd(8'h18, model(),  "R11 summary after write");
    rd(8'h10, rx_lvl_i, "R11 rx level after write");
    @(negedge clk);
    @(negedge clk);
    chk("R9 all reads answered", exp_q.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule